// File: doc/BRIEF.md
# Registered-Input Synchronous Static RAM

A small clocked static memory, eight words of four bits by default, sitting behind a shared bidirectional data bus. At every rising clock edge the block takes in the address, the three active-low strobes and the bus value, each into a register of its own. It then carries out the captured operation in the clock cycle that follows. A captured write stores the captured bus value into the captured word at the next edge. A captured read with output enable drives the word onto the bus for that one cycle. In every other cycle the block leaves the bus floating.

A host places its request on the pins before an edge and reads the answer on the bus during the next cycle. Reads and writes may follow each other on every edge. There is one exception. The cycle in which the block drives read data must not also be the cycle in which the host drives write data. The host therefore leaves one bus turnaround cycle between a driven read and any request during which it drives the bus.

The block has a companion output, `bus_drive`. It is high exactly while the block drives the data lines, so a pad ring or a bus keeper can follow the bus direction.

Top module: `ssram_core`

## Requirements
- R1: Address and strobes are taken only at the rising edge. The bus result in the cycle after edge k depends only on what was present at edge k, whatever the pins do during that cycle.
- R2: A read is captured when cs_n=0, we_n=1 and oe_n=0 at an edge. For the whole following cycle `bus_drive`=1 and `dq` carries the addressed word.
- R3: A write is captured when cs_n=0 and we_n=0 at an edge, whatever the value of oe_n. The `dq` value present at that edge is stored at the captured address. The block does not drive the bus in the following cycle.
- R4: A read captured with oe_n=1 leaves `bus_drive`=0 for the following cycle and changes no stored word.
- R5: When cs_n=1 at an edge, no operation takes place. `bus_drive` is 0 in the following cycle and every stored word is unchanged, even if we_n=0 and the bus carries data.
- R6: A write to address A, followed at the very next edge by a read of A, returns the newly written data.
- R7: While rst_n=0, `bus_drive` is 0. After reset, every word reads as 0 (option CLEAR_ON_RESET=1, the default).
- R8: With the defaults, the 3-bit address selects one of 8 independent words of 4 bits. A write to one address leaves all other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq | inout | DATA_W | Shared read/write data bus |
| bus_drive | output | 1 | High while the block drives `dq` |

## Verification
The main function is exercised with several input patterns:
- Full sweeps of all addresses after reset, then after a write pattern with a distinct value per word. These separate address decoding faults from storage faults.
- Back-to-back write-then-read pairs on one address. These show whether a read sees data committed at the same edge it was captured.
- Read sequences where the address and strobes change in the cycle after capture. These reveal any path from the pins to the bus that bypasses the input registers.
- Deselected writes with live bus data, and reads with output enable high. Each is followed by a read-back. These show that neither pattern touches the array or the bus direction.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

   // Decoded, active-high view of the captured strobes.
   typedef struct packed {
      logic sel;
      logic wr;
      logic oe;
   } ssram_ctl_t;

   localparam ssram_ctl_t SSRAM_CTL_IDLE = '{sel: 1'b0, wr: 1'b0, oe: 1'b0};

endpackage

// File: rtl/ssram_in_regs.sv
module ssram_in_regs
   import ssram_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   output ssram_ctl_t        ctl_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] din_q
);

   // Control register: reset to idle so nothing happens right after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= SSRAM_CTL_IDLE;
      end else begin
         ctl_q.sel <= ~cs_n;
         ctl_q.wr  <= ~we_n;
         ctl_q.oe  <= ~oe_n;
      end
   end

   // Address register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else begin
         addr_q <= addr_i;
      end
   end

   // Write-data register, sampled from the shared bus.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_q <= '0;
      end else begin
         din_q <= din_i;
      end
   end

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
   parameter int ADDR_W         = 3,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  mem[i] <= '0;
               end
            end else if (wr_en) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (wr_en) begin
               mem[waddr] <= wdata;
            end
         end
      end
   endgenerate

   // Read port is asynchronous to the array. The address feeding it is
   // already registered, so the read still completes in the cycle after
   // the capture.
   assign rdata = mem[raddr];

endmodule

// File: rtl/ssram_bus_ctl.sv
module ssram_bus_ctl
   import ssram_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  ssram_ctl_t        ctl_q,
   input  logic [DATA_W-1:0] rdata,
   output logic              drive_en,
   output logic [DATA_W-1:0] dout,
   output logic              wr_en
);

   // A selected cycle is either a write or a read; output enable only
   // matters for the read.
   always_comb begin
      wr_en    = ctl_q.sel & ctl_q.wr;
      drive_en = ctl_q.sel & ~ctl_q.wr & ctl_q.oe;
      dout     = drive_en ? rdata : '0;
   end

endmodule

// File: rtl/ssram_core.sv
module ssram_core
   import ssram_pkg::*;
#(
   parameter int ADDR_W         = 3,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [DATA_W-1:0] dq,
   output logic              bus_drive
);

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ssram_core: ADDR_W must lie in 1..12");
      end
      if (DATA_W < 1 || DATA_W > 256) begin : g_bad_data
         $error("ssram_core: DATA_W must lie in 1..256");
      end
   endgenerate

   ssram_ctl_t        ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;
   logic [DATA_W-1:0] rdata;
   logic [DATA_W-1:0] dout;
   logic              drive_en;
   logic              wr_en;

   ssram_in_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .we_n   (we_n),
      .oe_n   (oe_n),
      .addr_i (addr),
      .din_i  (dq),
      .ctl_q  (ctl_q),
      .addr_q (addr_q),
      .din_q  (din_q)
   );

   ssram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .waddr (addr_q),
      .wdata (din_q),
      .raddr (addr_q),
      .rdata (rdata)
   );

   ssram_bus_ctl #(.DATA_W(DATA_W)) u_bus (
      .ctl_q    (ctl_q),
      .rdata    (rdata),
      .drive_en (drive_en),
      .dout     (dout),
      .wr_en    (wr_en)
   );

   assign dq        = drive_en ? dout : {DATA_W{1'bz}};
   assign bus_drive = drive_en;

endmodule

// File: rtl/ssram_core_chk.sv
module ssram_core_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dq,
   input logic              bus_drive
);

   // Edges seen since reset release, saturating at 3.
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R7: assert (!bus_drive)
            else $error("bus driven during reset");
      end
   end

   assert_drive_only_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> $past(!cs_n && we_n && !oe_n))
      else $error("bus driven without a captured read");

   assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && $past(!cs_n && we_n && !oe_n)) |-> bus_drive)
      else $error("captured read did not drive the bus");

   assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_n && !we_n) |-> !bus_drive)
      else $error("bus driven after a write");

   assert_oe_high_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_n && we_n && oe_n) |-> !bus_drive)
      else $error("bus driven with output enable high");

   assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> !bus_drive)
      else $error("bus driven while deselected");

   assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(!cs_n && !we_n, 2) && $past(!cs_n && we_n && !oe_n)
       && ($past(addr) == $past(addr, 2))) |-> (dq == $past(dq, 2)))
      else $error("read after write returned stale data");

endmodule

bind ssram_core ssram_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .we_n      (we_n),
   .oe_n      (oe_n),
   .addr      (addr),
   .dq        (dq),
   .bus_drive (bus_drive)
);

// File: tb/ssram_core_tb.sv
module ssram_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 3;
   localparam int DATA_W     = 4;
   localparam int DEPTH      = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cs_n, we_n, oe_n;
   logic [ADDR_W-1:0] addr;
   logic              tb_en;
   logic [DATA_W-1:0] tb_val;
   wire  [DATA_W-1:0] dq;
   wire               bus_drive;

   assign dq = tb_en ? tb_val : {DATA_W{1'bz}};

   ssram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .we_n      (we_n),
      .oe_n      (oe_n),
      .addr      (addr),
      .dq        (dq),
      .bus_drive (bus_drive)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic              drive;
      logic [DATA_W-1:0] data;
      string             req;
   } exp_t;

   exp_t              sb[$];
   logic [DATA_W-1:0] model [DEPTH];
   int                n_tests = 0;
   int                n_fail  = 0;
   bit                prev_read_drive = 1'b0;
   bit                done = 1'b0;

   // Driver: one request per cycle, placed just after the falling edge.
   // The expectation is what the bus must show in the cycle after capture.
   task automatic put(input logic c, input logic w, input logic o,
                      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input string req);
      exp_t e;
      @(negedge clk); #1;
      cs_n = c; we_n = w; oe_n = o; addr = a;
      tb_en  = ~w;
      tb_val = d;
      e.req   = req;
      e.drive = ~c & w & ~o;
      e.data  = model[a];
      if (!c && !w) model[a] = d;
      sb.push_back(e);
      prev_read_drive = e.drive;
   endtask

   task automatic idle(input string req);
      put(1'b1, 1'b1, 1'b1, '0, '0, req);
   endtask

   // Any request that drives the bus needs a turnaround after a driven read.
   task automatic req_op(input logic c, input logic w, input logic o,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input string req);
      if (!w && prev_read_drive) idle(req);
      put(c, w, o, a, d, req);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string req);
      req_op(1'b0, 1'b0, 1'b1, a, d, req);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input string req);
      req_op(1'b0, 1'b1, 1'b0, a, '0, req);
   endtask

   // Monitor: pops one expectation per cycle, at the falling edge.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_tests++;
         if (bus_drive !== e.drive || (e.drive && dq !== e.data)) begin
            n_fail++;
            $display("FAIL %s: bus_drive=%0b dq=%h expected bus_drive=%0b dq=%h",
                     e.req, bus_drive, dq, e.drive, e.data);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0;
      tb_en = 1'b0; tb_val = '0;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      // R7: no drive while in reset, even with a read request on the pins.
      @(negedge clk); #1;
      cs_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      n_tests++;
      if (bus_drive !== 1'b0) begin
         n_fail++;
         $display("FAIL R7: bus_drive=%0b during reset expected 0", bus_drive);
      end
      #1; cs_n = 1'b1; oe_n = 1'b1;
      rst_n = 1'b1;

      // R7: all words clear after reset.
      for (int i = 0; i < DEPTH; i++) rd(i[ADDR_W-1:0], "R7");

      // R3 / R8: distinct value per word, then a full sweep.
      for (int i = 0; i < DEPTH; i++) wr(i[ADDR_W-1:0], DATA_W'((i * 5 + 3) & 15), "R3");
      for (int i = 0; i < DEPTH; i++) rd(i[ADDR_W-1:0], "R8");

      // R6: write then read on the same address at the next edge.
      wr(3'd2, 4'hA, "R6"); rd(3'd2, "R6");
      wr(3'd7, 4'h0, "R6"); rd(3'd7, "R6");
      wr(3'd0, 4'hF, "R6"); rd(3'd0, "R6");

      // R1: back-to-back reads, the pins change during each result cycle.
      rd(3'd1, "R1"); rd(3'd6, "R1"); rd(3'd2, "R1");
      idle("R1");

      // R4: read with output enable high, then confirm the word.
      req_op(1'b0, 1'b1, 1'b1, 3'd5, '0, "R4");
      rd(3'd5, "R4");

      // R5: deselected write with live bus data, then confirm the word.
      req_op(1'b1, 1'b0, 1'b0, 3'd4, 4'h6, "R5");
      req_op(1'b1, 1'b0, 1'b1, 3'd4, 4'h9, "R5");
      rd(3'd4, "R5");

      // R3: output enable low during a write does not turn on the bus.
      req_op(1'b0, 1'b0, 1'b0, 3'd3, 4'h5, "R3");
      rd(3'd3, "R3");

      // R8: neighbours untouched after all the above.
      for (int i = 0; i < DEPTH; i++) rd(i[ADDR_W-1:0], "R8");

      idle("R2");
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule